// File: doc/BRIEF.md
# Endpoint test command engine

This block is the register front end and command sequencer of a loopback test function that sits behind a host bus. Software on the host programs a scratch pattern, a source and a destination buffer address, a transfer length in bytes, an expected checksum and interrupt settings through a 32-bit register slave port. It then writes a command word. The engine either raises an interrupt, reads a host buffer, fills a host buffer with a generated pattern, or copies one host buffer to another. The buffer operations go through a word-wide request/acknowledge memory port.

When a buffer operation ends, the engine posts result flags into the status register and emits a one-cycle interrupt request. The request carries the kind held in the interrupt-kind register and the vector held in the interrupt-vector register. A read compares the sum of the words it fetched against the checksum register. A pattern write leaves the sum of the words it stored in that register. Addresses are checked before any access is issued, so a bad pointer gives a clean failure report rather than a bus access.

Top module: `ept_cmd_engine`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, `mem_req` is low and `irq_valid` is low.
- R2: The pattern register at word index 0 is plain read/write storage and returns exactly what was last written.
- R3: Registers sit at word indices: 0 pattern, 1 command, 2 status (read-only), 3 source address, 4 destination address, 5 length, 6 checksum, 7 interrupt kind, 8 interrupt vector; `host_rdata` holds the addressed value from the clock edge after a read request.
- R4: Command bits: 0 legacy interrupt, 1 MSI, 2 MSI-X, 3 buffer read, 4 pattern write, 5 copy; when several bits are set the lowest set bit alone is executed. An interrupt command sets status bit 6 and emits kind 0, 1 or 2 respectively with no memory access.
- R5: A read fetches ceil(length/4) words from source+4*i. It sets status bit 0 when their 32-bit wrapping sum equals the checksum register and bit 1 otherwise; the checksum register is left unchanged.
- R6: A pattern write stores word value pattern+i to destination+4*i for ceil(length/4) words, writes the wrapping sum of those words to the checksum register and sets status bit 2.
- R7: A copy moves ceil(length/4) words from source+4*i to destination+4*i and sets status bit 4.
- R8: An address of zero or with bits [1:0] non-zero is invalid. If a used address is invalid, the command makes no memory request and sets its fail bit (read 1, write 3, copy 5), plus bit 7 for a bad source and/or bit 8 for a bad destination.
- R9: A length of zero completes with the success bit, no memory access, and (for a pattern write) a checksum of zero.
- R10: Every command ends by setting status bit 6 and pulsing `irq_valid` for one cycle with `irq_num` equal to the vector register. A buffer command takes `irq_kind` from the interrupt-kind register.
- R11: An accepted command-register write clears status and the command register returns to zero once the engine takes it. A command write while a command is pending or executing, including its final cycle, is dropped and leaves status unchanged.
- R12: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle `mem_ack` is seen; every request address is word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_en | input | 1 | Host register access strobe |
| host_we | input | 1 | 1 = register write, 0 = register read |
| host_addr | input | 4 | Register word index |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_kind | output | 2 | Interrupt kind: 0 legacy, 1 MSI, 2 MSI-X |
| irq_num | output | 11 | Interrupt vector |

## Verification
A host command-register write and the engine's completion can land on the same clock edge. In that case the status update and the status clear would compete. The bench holds the memory acknowledge off, releases it on a chosen falling edge, and times a command write so that it is sampled exactly in the finishing cycle. It then requires that the status reads the full read-success result with no trace of a clear, that the command register reads zero, and that only one interrupt appeared.

// File: rtl/ept_pkg.sv
// Package: shared constants, encodings and the command priority picker
// for the endpoint test command engine. Assumes a 9-entry register map.
package ept_pkg;

    localparam int RA_W   = 4;
    localparam int CMD_W  = 6;
    localparam int STAT_W = 9;

    // register word indices (host visible order)
    localparam logic [RA_W-1:0] RG_PATTERN = 4'd0;
    localparam logic [RA_W-1:0] RG_CMD     = 4'd1;
    localparam logic [RA_W-1:0] RG_STAT    = 4'd2;
    localparam logic [RA_W-1:0] RG_SRC     = 4'd3;
    localparam logic [RA_W-1:0] RG_DST     = 4'd4;
    localparam logic [RA_W-1:0] RG_LEN     = 4'd5;
    localparam logic [RA_W-1:0] RG_SUM     = 4'd6;
    localparam logic [RA_W-1:0] RG_IKIND   = 4'd7;
    localparam logic [RA_W-1:0] RG_IVEC    = 4'd8;

    // status bit positions
    localparam int SB_RD_OK   = 0;
    localparam int SB_RD_BAD  = 1;
    localparam int SB_WR_OK   = 2;
    localparam int SB_WR_BAD  = 3;
    localparam int SB_CP_OK   = 4;
    localparam int SB_CP_BAD  = 5;
    localparam int SB_IRQ     = 6;
    localparam int SB_SRC_INV = 7;
    localparam int SB_DST_INV = 8;

    // interrupt kind codes
    localparam int KIND_LEG  = 0;
    localparam int KIND_MSI  = 1;
    localparam int KIND_MSIX = 2;

    typedef enum logic [2:0] {
        OP_NONE, OP_LEG, OP_MSI, OP_MSIX, OP_READ, OP_WRITE, OP_COPY
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_RD, ST_WR, ST_FIN
    } seq_st_e;

    // lowest set command bit wins
    function automatic op_e pick_op(input logic [CMD_W-1:0] c);
        op_e r;
        if (c[0])      r = OP_LEG;
        else if (c[1]) r = OP_MSI;
        else if (c[2]) r = OP_MSIX;
        else if (c[3]) r = OP_READ;
        else if (c[4]) r = OP_WRITE;
        else if (c[5]) r = OP_COPY;
        else           r = OP_NONE;
        return r;
    endfunction

endpackage

// File: rtl/ept_addr_chk.sv
// Address validity check: flags an address that is zero or not aligned
// to a 32-bit word. Purely combinational; assumes byte addressing.
module ept_addr_chk #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    output logic          bad
);
    // zero or misaligned pointer is rejected
    always_comb bad = (addr == '0) || (addr[1:0] != 2'b00);
endmodule

// File: rtl/ept_regs.sv
// Register file and host decode. Holds the nine host registers, drops
// command writes while the engine is busy or a command is pending, clears
// the command on take, merges completion flags into status and lets the
// engine overwrite the checksum. Read data is registered one cycle.
module ept_regs
    import ept_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 32,
    parameter int TYPE_W = 2,
    parameter int NUM_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [RA_W-1:0]   host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    input  logic              eng_busy,
    input  logic              take,
    input  logic              fin,
    input  logic [STAT_W-1:0] fin_flags,
    input  logic              sum_we,
    input  logic [DW-1:0]     sum_val,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [STAT_W-1:0] stat_q,
    output logic [DW-1:0]     pat_q,
    output logic [AW-1:0]     src_q,
    output logic [AW-1:0]     dst_q,
    output logic [DW-1:0]     len_q,
    output logic [DW-1:0]     sum_q,
    output logic [TYPE_W-1:0] ikind_q,
    output logic [NUM_W-1:0]  ivec_q
);
    logic wr_hit;
    logic cmd_block;

    // host write strobe and command lock
    always_comb begin
        wr_hit    = host_en && host_we;
        cmd_block = eng_busy || (cmd_q != '0);
    end

    // register storage updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            stat_q  <= '0;
            pat_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            len_q   <= '0;
            sum_q   <= '0;
            ikind_q <= '0;
            ivec_q  <= '0;
        end else begin
            if (wr_hit) begin
                case (host_addr)
                    RG_PATTERN: pat_q   <= host_wdata;
                    RG_CMD: begin
                        if (!cmd_block) begin
                            cmd_q  <= host_wdata[CMD_W-1:0];
                            stat_q <= '0;
                        end
                    end
                    RG_SRC:     src_q   <= host_wdata[AW-1:0];
                    RG_DST:     dst_q   <= host_wdata[AW-1:0];
                    RG_LEN:     len_q   <= host_wdata;
                    RG_SUM:     sum_q   <= host_wdata;
                    RG_IKIND:   ikind_q <= host_wdata[TYPE_W-1:0];
                    RG_IVEC:    ivec_q  <= host_wdata[NUM_W-1:0];
                    default: ;
                endcase
            end
            if (take)   cmd_q  <= '0;
            if (fin)    stat_q <= stat_q | fin_flags;
            if (sum_we) sum_q  <= sum_val;
        end
    end

    // registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_en && !host_we) begin
            case (host_addr)
                RG_PATTERN: host_rdata <= pat_q;
                RG_CMD:     host_rdata <= DW'(cmd_q);
                RG_STAT:    host_rdata <= DW'(stat_q);
                RG_SRC:     host_rdata <= DW'(src_q);
                RG_DST:     host_rdata <= DW'(dst_q);
                RG_LEN:     host_rdata <= len_q;
                RG_SUM:     host_rdata <= sum_q;
                RG_IKIND:   host_rdata <= DW'(ikind_q);
                RG_IVEC:    host_rdata <= DW'(ivec_q);
                default:    host_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ept_seq.sv
// Command sequencer. Takes a pending command when idle, validates the
// addresses it needs, walks the word loop over the memory port, keeps the
// running sum and finishes with status flags and an interrupt pulse.
// Assumes mem_ack comes one cycle per request while mem_req is held.
module ept_seq
    import ept_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 32,
    parameter int TYPE_W = 2,
    parameter int NUM_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_q,
    input  logic [DW-1:0]     pat_q,
    input  logic [AW-1:0]     src_q,
    input  logic [AW-1:0]     dst_q,
    input  logic [DW-1:0]     len_q,
    input  logic [DW-1:0]     sum_ref,
    input  logic [TYPE_W-1:0] ikind_q,
    input  logic [NUM_W-1:0]  ivec_q,
    output logic              take,
    output logic              busy,
    output logic              fin,
    output logic [STAT_W-1:0] fin_flags,
    output logic              sum_we,
    output logic [DW-1:0]     sum_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              irq_valid,
    output logic [TYPE_W-1:0] irq_kind,
    output logic [NUM_W-1:0]  irq_num
);
    localparam int CNT_W = DW - 1;
    localparam int NCHK  = 2;

    seq_st_e           state_q;
    op_e               op_q, op_sel;
    logic [AW-1:0]     src_l, dst_l;
    logic [DW-1:0]     pat_l, ref_l, sum_q, hold_q;
    logic [CNT_W-1:0]  nw_q, idx_q, idx_nxt, nw_in;
    logic              zero_q, bad_src_q, bad_dst_q;
    logic [TYPE_W-1:0] kind_q;
    logic [NUM_W-1:0]  num_q;
    logic [AW-1:0]     chk_addr [NCHK];
    logic [NCHK-1:0]   chk_bad;
    logic              need_src, need_dst, abort, last;
    logic [TYPE_W-1:0] kind_sel;

    // one validity checker per pointer (0 source, 1 destination)
    always_comb begin
        chk_addr[0] = src_q;
        chk_addr[1] = dst_q;
    end

    for (genvar g = 0; g < NCHK; g++) begin : g_chk
        ept_addr_chk #(.AW(AW)) u_chk (.addr(chk_addr[g]), .bad(chk_bad[g]));
    end

    // command decode at take time
    always_comb begin
        op_sel   = pick_op(cmd_q);
        take     = (state_q == ST_IDLE) && (cmd_q != '0);
        busy     = (state_q != ST_IDLE);
        need_src = (op_sel == OP_READ)  || (op_sel == OP_COPY);
        need_dst = (op_sel == OP_WRITE) || (op_sel == OP_COPY);
        abort    = (need_src && chk_bad[0]) || (need_dst && chk_bad[1]);
        nw_in    = CNT_W'(len_q[DW-1:2]) + CNT_W'(|len_q[1:0]);
        case (op_sel)
            OP_LEG:  kind_sel = TYPE_W'(KIND_LEG);
            OP_MSI:  kind_sel = TYPE_W'(KIND_MSI);
            OP_MSIX: kind_sel = TYPE_W'(KIND_MSIX);
            default: kind_sel = ikind_q;
        endcase
    end

    // loop index and memory port drive
    always_comb begin
        idx_nxt   = idx_q + CNT_W'(1);
        last      = (idx_nxt == nw_q);
        mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
        mem_we    = (state_q == ST_WR);
        mem_addr  = ((state_q == ST_RD) ? src_l : dst_l) + (AW'(idx_q) << 2);
        mem_wdata = (op_q == OP_COPY) ? hold_q : pat_l + DW'(idx_q);
    end

    // sequencer state, operands and running sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_NONE;
            src_l     <= '0;
            dst_l     <= '0;
            pat_l     <= '0;
            ref_l     <= '0;
            sum_q     <= '0;
            hold_q    <= '0;
            nw_q      <= '0;
            idx_q     <= '0;
            zero_q    <= 1'b0;
            bad_src_q <= 1'b0;
            bad_dst_q <= 1'b0;
            kind_q    <= '0;
            num_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        op_q      <= op_sel;
                        src_l     <= src_q;
                        dst_l     <= dst_q;
                        pat_l     <= pat_q;
                        ref_l     <= sum_ref;
                        nw_q      <= nw_in;
                        idx_q     <= '0;
                        sum_q     <= '0;
                        zero_q    <= (nw_in == '0);
                        bad_src_q <= need_src && chk_bad[0];
                        bad_dst_q <= need_dst && chk_bad[1];
                        kind_q    <= kind_sel;
                        num_q     <= ivec_q;
                        if (!(need_src || need_dst) || abort || nw_in == '0)
                            state_q <= ST_FIN;
                        else if (op_sel == OP_WRITE)
                            state_q <= ST_WR;
                        else
                            state_q <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_ack) begin
                        hold_q <= mem_rdata;
                        sum_q  <= sum_q + mem_rdata;
                        if (op_q == OP_COPY) begin
                            state_q <= ST_WR;
                        end else begin
                            idx_q <= idx_nxt;
                            if (last) state_q <= ST_FIN;
                        end
                    end
                end
                ST_WR: begin
                    if (mem_ack) begin
                        if (op_q == OP_WRITE) sum_q <= sum_q + mem_wdata;
                        idx_q <= idx_nxt;
                        if (last)                  state_q <= ST_FIN;
                        else if (op_q == OP_COPY)  state_q <= ST_RD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // completion flags and checksum store
    always_comb begin
        fin       = (state_q == ST_FIN);
        fin_flags = '0;
        fin_flags[SB_IRQ] = 1'b1;
        case (op_q)
            OP_READ: begin
                if (bad_src_q) begin
                    fin_flags[SB_SRC_INV] = 1'b1;
                    fin_flags[SB_RD_BAD]  = 1'b1;
                end else if (zero_q || sum_q == ref_l) begin
                    fin_flags[SB_RD_OK]   = 1'b1;
                end else begin
                    fin_flags[SB_RD_BAD]  = 1'b1;
                end
            end
            OP_WRITE: begin
                if (bad_dst_q) begin
                    fin_flags[SB_DST_INV] = 1'b1;
                    fin_flags[SB_WR_BAD]  = 1'b1;
                end else begin
                    fin_flags[SB_WR_OK]   = 1'b1;
                end
            end
            OP_COPY: begin
                if (bad_src_q || bad_dst_q) begin
                    fin_flags[SB_CP_BAD]  = 1'b1;
                    fin_flags[SB_SRC_INV] = bad_src_q;
                    fin_flags[SB_DST_INV] = bad_dst_q;
                end else begin
                    fin_flags[SB_CP_OK]   = 1'b1;
                end
            end
            default: ;
        endcase
        sum_we  = fin && (op_q == OP_WRITE) && !bad_dst_q;
        sum_val = sum_q;
    end

    // registered interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_kind  <= '0;
            irq_num   <= '0;
        end else begin
            irq_valid <= fin;
            if (fin) begin
                irq_kind <= kind_q;
                irq_num  <= num_q;
            end
        end
    end
endmodule

// File: rtl/ept_cmd_engine.sv
// Top: endpoint test command engine. Joins the register file and the
// sequencer; host slave port, memory master port and interrupt request.
// Assumes a single clock and synchronous active-low reset.
module ept_cmd_engine
    import ept_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 32,
    parameter int TYPE_W = 2,
    parameter int NUM_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [RA_W-1:0]   host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              irq_valid,
    output logic [TYPE_W-1:0] irq_kind,
    output logic [NUM_W-1:0]  irq_num
);
    logic [CMD_W-1:0]  cmd_q;
    logic [STAT_W-1:0] stat_q;
    logic [DW-1:0]     pat_q, len_q, sum_q, sum_val;
    logic [AW-1:0]     src_q, dst_q;
    logic [TYPE_W-1:0] ikind_q;
    logic [NUM_W-1:0]  ivec_q;
    logic              seq_busy, seq_take, seq_fin, sum_we;
    logic [STAT_W-1:0] fin_flags;

    ept_regs #(.DW(DW), .AW(AW), .TYPE_W(TYPE_W), .NUM_W(NUM_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_busy(seq_busy), .take(seq_take), .fin(seq_fin),
        .fin_flags(fin_flags), .sum_we(sum_we), .sum_val(sum_val),
        .cmd_q(cmd_q), .stat_q(stat_q), .pat_q(pat_q), .src_q(src_q),
        .dst_q(dst_q), .len_q(len_q), .sum_q(sum_q),
        .ikind_q(ikind_q), .ivec_q(ivec_q)
    );

    ept_seq #(.DW(DW), .AW(AW), .TYPE_W(TYPE_W), .NUM_W(NUM_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_q(cmd_q), .pat_q(pat_q), .src_q(src_q), .dst_q(dst_q),
        .len_q(len_q), .sum_ref(sum_q), .ikind_q(ikind_q), .ivec_q(ivec_q),
        .take(seq_take), .busy(seq_busy), .fin(seq_fin),
        .fin_flags(fin_flags), .sum_we(sum_we), .sum_val(sum_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_valid(irq_valid), .irq_kind(irq_kind), .irq_num(irq_num)
    );
endmodule

// File: rtl/ept_cmd_engine_chk.sv
// Checker: temporal rules of the engine's memory port, interrupt pulse,
// command lock and status encoding. Bound into every ept_cmd_engine.
module ept_cmd_engine_chk
    import ept_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic [DW-1:0]     mem_wdata,
    input logic              irq_valid,
    input logic              fin,
    input logic              eng_busy,
    input logic [CMD_W-1:0]  cmd_q,
    input logic [STAT_W-1:0] stat_q
);
    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R12
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    // R10
    fin_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> irq_valid);

    // R11
    cmd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> (cmd_q == '0));

    // R5
    read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_q[SB_RD_OK] && stat_q[SB_RD_BAD]));

    // R6
    write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_q[SB_WR_OK] && stat_q[SB_WR_BAD]));

    // R7
    copy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_q[SB_CP_OK] && stat_q[SB_CP_BAD]));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !irq_valid));
endmodule

bind ept_cmd_engine ept_cmd_engine_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .irq_valid(irq_valid), .fin(seq_fin), .eng_busy(seq_busy),
    .cmd_q(cmd_q), .stat_q(stat_q)
);

// File: tb/ept_cmd_engine_test.sv
`timescale 1ns/1ps
module ept_cmd_engine_test;

    localparam int LAT = 1;
    localparam logic [31:0] PAT = 32'hC3A5_0F00;

    typedef struct packed {
        logic [5:0]  cmd;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] len;
        logic        good;
        logic [8:0]  st;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{6'h08, 32'h10, 32'h00, 32'd16, 1'b1, 9'h041, 2'd1},
        '{6'h08, 32'h10, 32'h00, 32'd16, 1'b0, 9'h042, 2'd1},
        '{6'h10, 32'h00, 32'h80, 32'd12, 1'b0, 9'h044, 2'd1},
        '{6'h20, 32'h20, 32'hC0, 32'd8,  1'b0, 9'h050, 2'd1},
        '{6'h08, 32'h00, 32'h00, 32'd4,  1'b1, 9'h0C2, 2'd1},
        '{6'h10, 32'h00, 32'h42, 32'd4,  1'b0, 9'h148, 2'd1},
        '{6'h20, 32'h03, 32'h00, 32'd4,  1'b0, 9'h1E0, 2'd1},
        '{6'h10, 32'h00, 32'h90, 32'd0,  1'b0, 9'h044, 2'd1},
        '{6'h08, 32'h30, 32'h00, 32'd5,  1'b1, 9'h041, 2'd1},
        '{6'h18, 32'h10, 32'h80, 32'd8,  1'b1, 9'h041, 2'd1},
        '{6'h01, 32'h00, 32'h00, 32'd0,  1'b0, 9'h040, 2'd0},
        '{6'h24, 32'h20, 32'hC0, 32'd8,  1'b0, 9'h040, 2'd2},
        '{6'h02, 32'h00, 32'h00, 32'd0,  1'b0, 9'h040, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_en, host_we;
    logic [3:0]  host_addr;
    logic [31:0] host_wdata, host_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq_valid;
    logic [1:0]  irq_kind;
    logic [10:0] irq_num;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] mem [64];
    bit stall = 0;
    int wait_cnt = 0;
    int acc_cnt = 0;
    int irq_cnt = 0;
    logic [1:0]  last_kind = '0;
    logic [10:0] last_num = '0;

    always #2 clk = ~clk;

    ept_cmd_engine uut (
        .clk(clk), .rst_n(rst_n),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_valid(irq_valid), .irq_kind(irq_kind), .irq_num(irq_num)
    );

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_en = 1'b0;
        d = host_rdata;
    endtask

    task automatic wait_done(output logic [31:0] st);
        st = '0;
        for (int k = 0; k < 400; k++) begin
            bus_rd(4'd2, st);
            if (st != '0) break;
        end
    endtask

    function automatic int low_bit(input logic [5:0] c);
        for (int b = 0; b < 6; b++) if (c[b]) return b;
        return 6;
    endfunction

    function automatic string tag_of(input vec_t v);
        int b;
        b = low_bit(v.cmd);
        if (v.st[8:7] != 2'b00) return "R8";
        if (b < 3) return "R4";
        if (v.len == 0) return "R9";
        if (b == 3) return "R5";
        if (b == 4) return "R6";
        return "R7";
    endfunction

    // memory responder: acknowledges after LAT held cycles unless stalled
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (wait_cnt >= LAT && !stall) begin
                    mem_ack = 1'b1;
                    acc_cnt++;
                    if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
                    else        mem_rdata = mem[mem_addr[7:2]];
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    // interrupt monitor
    initial begin
        forever begin
            @(negedge clk);
            if (irq_valid) begin
                irq_cnt++;
                last_kind = irq_kind;
                last_num  = irq_num;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv, st, s, nw, acc0, irq0;
        logic [31:0] snap [8];
        vec_t v;
        int b;

        for (int i = 0; i < 64; i++) mem[i] = 32'h1357_0000 + i * 32'h0001_0203;
        rst_n = 1'b0;
        host_en = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", {31'd0, mem_req}, 32'd0, "mem_req in reset");
        chk("R1", {31'd0, irq_valid}, 32'd0, "irq_valid in reset");
        rst_n = 1'b1;
        for (int a = 0; a < 9; a++) begin
            bus_rd(4'(a), rv);
            chk("R1", rv, 32'd0, $sformatf("reg %0d after reset", a));
        end

        // R2: pattern register storage
        bus_wr(4'd0, 32'h5A5A_1234);
        bus_rd(4'd0, rv);
        chk("R2", rv, 32'h5A5A_1234, "pattern readback");
        bus_wr(4'd0, PAT);
        bus_rd(4'd0, rv);
        chk("R2", rv, PAT, "pattern rewrite");

        // R3: register positions
        bus_wr(4'd3, 32'h0000_0A10);
        bus_wr(4'd4, 32'h0000_0B20);
        bus_wr(4'd5, 32'h0000_0333);
        bus_wr(4'd8, 32'h0000_0155);
        bus_wr(4'd7, 32'h0000_0001);
        bus_rd(4'd3, rv); chk("R3", rv, 32'h0A10, "source index 3");
        bus_rd(4'd4, rv); chk("R3", rv, 32'h0B20, "destination index 4");
        bus_rd(4'd5, rv); chk("R3", rv, 32'h0333, "length index 5");
        bus_rd(4'd8, rv); chk("R3", rv, 32'h0155, "vector index 8");
        bus_rd(4'd7, rv); chk("R3", rv, 32'h0001, "kind index 7");
        bus_wr(4'd2, 32'h0000_01FF);
        bus_rd(4'd2, rv); chk("R3", rv, 32'h0, "status read-only");

        // table of commands
        for (int n = 0; n < NV; n++) begin
            v = VECS[n];
            b = low_bit(v.cmd);
            nw = (v.len + 3) >> 2;
            bus_wr(4'd3, v.src);
            bus_wr(4'd4, v.dst);
            bus_wr(4'd5, v.len);
            s = '0;
            for (int i = 0; i < 32'(nw); i++) s += mem[((v.src >> 2) + i) & 63];
            if (b == 3) bus_wr(4'd6, v.good ? s : ~s);
            for (int i = 0; i < 8; i++) snap[i] = mem[((v.src >> 2) + i) & 63];
            acc0 = acc_cnt;
            irq0 = irq_cnt;
            bus_wr(4'd1, {26'd0, v.cmd});
            wait_done(st);
            chk(tag_of(v), st, {23'd0, v.st}, $sformatf("status vec %0d", n));
            // R10: one interrupt of the expected kind and vector
            chk("R10", irq_cnt, irq0 + 1, $sformatf("irq count vec %0d", n));
            chk("R10", {30'd0, last_kind}, {30'd0, v.kind}, $sformatf("irq kind vec %0d", n));
            chk("R10", {21'd0, last_num}, 32'h155, $sformatf("irq vector vec %0d", n));
            bus_rd(4'd1, rv);
            chk("R11", rv, 32'd0, $sformatf("command self-clear vec %0d", n));
            if (b < 3 || v.st[8:7] != 2'b00 || v.len == 0)
                chk(tag_of(v), acc_cnt, acc0, $sformatf("no memory access vec %0d", n));
            if (v.st[2]) begin
                s = '0;
                for (int i = 0; i < 32'(nw); i++) begin
                    s += PAT + i;
                    chk(tag_of(v), mem[((v.dst >> 2) + i) & 63], PAT + i,
                        $sformatf("written word %0d vec %0d", i, n));
                end
                bus_rd(4'd6, rv);
                chk(tag_of(v), rv, s, $sformatf("stored checksum vec %0d", n));
            end
            if (v.st[4]) begin
                for (int i = 0; i < 32'(nw); i++)
                    chk("R7", mem[((v.dst >> 2) + i) & 63], snap[i],
                        $sformatf("copied word %0d vec %0d", i, n));
            end
        end

        // R11: a zero command write still clears status
        bus_wr(4'd1, 32'd0);
        bus_rd(4'd2, rv);
        chk("R11", rv, 32'd0, "status cleared by command write");

        // R11: command during execution is dropped; R12 request held
        bus_wr(4'd3, 32'h10);
        bus_wr(4'd5, 32'd4);
        bus_wr(4'd6, mem[4]);
        @(negedge clk); #1 stall = 1'b1;
        irq0 = irq_cnt;
        bus_wr(4'd1, 32'h08);
        bus_wr(4'd1, 32'h01);
        bus_rd(4'd1, rv);
        chk("R11", rv, 32'd0, "command while busy not stored");
        @(negedge clk);
        acc0 = mem_addr;
        @(negedge clk);
        chk("R12", {31'd0, mem_req}, 32'd1, "request held while stalled");
        chk("R12", mem_addr, acc0, "address stable while stalled");
        chk("R12", mem_addr, 32'h10, "request address");
        #1 stall = 1'b0;
        wait_done(st);
        chk("R11", st, 32'h041, "status after dropped command");
        repeat (10) @(negedge clk);
        chk("R11", irq_cnt, irq0 + 1, "dropped command never runs");

        // R11: command write sampled in the finishing cycle is dropped
        bus_wr(4'd1, 32'd0);
        irq0 = irq_cnt;
        @(negedge clk); #1 stall = 1'b1;
        bus_wr(4'd1, 32'h08);
        repeat (5) @(negedge clk);
        #1 stall = 1'b0;
        @(negedge clk);
        bus_wr(4'd1, 32'h01);
        bus_rd(4'd1, rv);
        chk("R11", rv, 32'd0, "finish-cycle command not stored");
        wait_done(st);
        chk("R11", st, 32'h041, "finish-cycle status intact");
        repeat (10) @(negedge clk);
        chk("R11", irq_cnt, irq0 + 1, "finish-cycle single interrupt");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule